// File: doc/BRIEF.md
# Prioritized Pending Interrupt Queue

This block holds interrupt requests that are waiting to be taken. Every request is turned into an entry with a numeric kind, and a larger kind means a higher priority. The queue keeps its entries sorted by kind in ascending order, so the entry the core should take next always sits at the tail. Each entry records its request class, handler offset, instruction address and issue slot.

Requests come from four classes: external (levels 1 to 15), software trap, program exception and break. External requests pass through an enable and level mask, and a second request for a level that is already queued is merged into the first. The core reads the tail entry from the outputs and removes it with an acknowledge pulse. A single flush removes every entry whose class falls inside an inclusive class range.

Top module: `irq_pending_queue`

## Requirements
- R1: After a synchronous reset, `count` is 0, `top_valid` is 0 and `overflow` is 0.
- R2: Kinds are encoded as follows: external level L is L-1, software trap is 15, program cause c (0 to 7) is 16+c, and break is 24. Class codes are external 0, software 1, program 2 and break 3. The outputs always show the queued entry with the highest kind.
- R3: A new entry is placed below every existing entry of equal or greater kind. Among non-external entries of equal kind, the one enqueued earlier is therefore presented first.
- R4: An external request is dropped if `trap_en` is 0, or if its level is 0, or if its level is not greater than `pil`, except in the case covered by R5.
- R5: An external level 15 request is never dropped by the `pil` comparison. It is still dropped when `trap_en` is 0.
- R6: An external request whose kind is already queued leaves the queue unchanged, and the stored entry keeps its original address and slot.
- R7: Handler offsets are as follows: external level L uses 0x20+L, break uses 0xFF, software trap uses `enq_sw_offset`, and program causes 0 to 7 use 0x19, 0x17, 0x14, 0x13, 0x12, 0x11, 0x0E and 0x0D.
- R8: `pop` removes the tail entry. A `pop` on an empty queue has no effect.
- R9: When `flush_en` is high, every entry whose class lies between `flush_lo` and `flush_hi` inclusive is removed. The remaining entries keep their order and `count` drops to match.
- R10: A request that would create a new entry while the queue holds DEPTH entries is discarded and sets `overflow`. `overflow` is cleared only by reset.
- R11: Within one cycle, the pop is applied first, then the flush, then the insertion. A pop together with an enqueue on a full queue therefore accepts the new entry without overflow.
- R12: Each entry stores the `enq_pc` and `enq_slot` that came with its request, and these appear on `top_pc` and `top_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_en | input | 1 | Global enable for external requests |
| pil | input | 4 | Current priority level; external requests at or below it are masked |
| enq_valid | input | 1 | Enqueue request strobe |
| enq_cls | input | 2 | Request class (0 ext, 1 soft, 2 prog, 3 break) |
| enq_level | input | 4 | External level 1..15 |
| enq_code | input | 3 | Program cause code |
| enq_sw_offset | input | 8 | Handler offset for a software trap |
| enq_pc | input | 32 | Address of the raising instruction |
| enq_slot | input | 3 | Issue slot of the raising instruction |
| pop | input | 1 | Acknowledge: remove the tail entry |
| flush_en | input | 1 | Flush a class range |
| flush_lo | input | 2 | Lowest class to flush |
| flush_hi | input | 2 | Highest class to flush |
| top_valid | output | 1 | Queue is not empty |
| top_kind | output | 5 | Kind of the tail entry |
| top_cls | output | 2 | Class of the tail entry |
| top_offset | output | 8 | Handler offset of the tail entry |
| top_pc | output | 32 | Stored address of the tail entry |
| top_slot | output | 3 | Stored slot of the tail entry |
| count | output | 4 | Number of queued entries |
| overflow | output | 1 | Sticky flag: a request was lost to a full queue |

## Verification
The bench goes after the masking edges. A level equal to `pil` must be masked, and level 15 must get through at `pil` 15; a comparison that is off by one lets one of these through or blocks the other. It enqueues the same external level twice and checks that the second address never appears, which an insertion that skips the duplicate test would expose. It also enqueues equal program kinds and checks which address comes out first, which exposes a tie rule that inserts on the wrong side. Finally it fills the queue, overflows it, and then pops and enqueues in one cycle while full. A design that checks fullness before applying the pop would drop that entry, and a flag that is not sticky would clear.

// File: rtl/irq_queue_pkg.sv
package irq_queue_pkg;

    localparam int PC_W     = 32;
    localparam int SLOT_W   = 3;
    localparam int LVL_W    = 4;
    localparam int OFF_W    = 8;
    localparam int NPROG    = 8;
    localparam int CODE_W   = $clog2(NPROG);
    localparam int KIND_SWT   = (1 << LVL_W) - 1;
    localparam int KIND_PROG0 = KIND_SWT + 1;
    localparam int KIND_BRK   = KIND_PROG0 + NPROG;
    localparam int KIND_W     = $clog2(KIND_BRK + 1);
    localparam int LVL_TOP    = (1 << LVL_W) - 1;

    typedef enum logic [1:0] {
        CLS_EXT  = 2'd0,
        CLS_SWT  = 2'd1,
        CLS_PROG = 2'd2,
        CLS_BRK  = 2'd3
    } irq_class_e;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        irq_class_e        cls;
        logic [OFF_W-1:0]  offset;
        logic [PC_W-1:0]   pc;
        logic [SLOT_W-1:0] slot;
    } irq_entry_t;

    function automatic logic [OFF_W-1:0] prog_offset(input logic [CODE_W-1:0] code);
        logic [OFF_W-1:0] v;
        case (code)
            3'd0:    v = 8'h19;
            3'd1:    v = 8'h17;
            3'd2:    v = 8'h14;
            3'd3:    v = 8'h13;
            3'd4:    v = 8'h12;
            3'd5:    v = 8'h11;
            3'd6:    v = 8'h0E;
            default: v = 8'h0D;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
    import irq_queue_pkg::*;
(
    input  logic              enq_valid,
    input  logic [1:0]        enq_cls,
    input  logic [LVL_W-1:0]  enq_level,
    input  logic [CODE_W-1:0] enq_code,
    input  logic [OFF_W-1:0]  enq_sw_offset,
    input  logic [PC_W-1:0]   enq_pc,
    input  logic [SLOT_W-1:0] enq_slot,
    input  logic              trap_en,
    input  logic [LVL_W-1:0]  pil,
    output logic              req_ok,
    output irq_entry_t        req_entry
);
    irq_class_e cls;
    logic       ext_pass;

    always_comb begin
        cls      = irq_class_e'(enq_cls);
        ext_pass = trap_en && (enq_level != '0) &&
                   ((enq_level == LVL_W'(LVL_TOP)) || (enq_level > pil));

        req_entry      = '0;
        req_entry.cls  = cls;
        req_entry.pc   = enq_pc;
        req_entry.slot = enq_slot;
        req_ok         = enq_valid;

        case (cls)
            CLS_EXT: begin
                req_entry.kind   = KIND_W'(enq_level) - KIND_W'(1);
                req_entry.offset = OFF_W'(8'h20) + OFF_W'(enq_level);
                req_ok           = enq_valid && ext_pass;
            end
            CLS_SWT: begin
                req_entry.kind   = KIND_W'(KIND_SWT);
                req_entry.offset = enq_sw_offset;
            end
            CLS_PROG: begin
                req_entry.kind   = KIND_W'(KIND_PROG0) + KIND_W'(enq_code);
                req_entry.offset = prog_offset(enq_code);
            end
            default: begin
                req_entry.kind   = KIND_W'(KIND_BRK);
                req_entry.offset = 8'hFF;
            end
        endcase
    end
endmodule

// File: rtl/irq_queue_flush.sv
module irq_queue_flush
    import irq_queue_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  irq_entry_t       q_in  [DEPTH],
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             flush_en,
    input  logic [1:0]       flush_lo,
    input  logic [1:0]       flush_hi,
    output irq_entry_t       q_out [DEPTH],
    output logic [CNT_W-1:0] cnt_out
);
    logic [CNT_W-1:0] dst;
    logic             keep;

    always_comb begin
        for (int j = 0; j < DEPTH; j++) q_out[j] = '0;
        dst  = '0;
        keep = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            keep = (CNT_W'(i) < cnt_in) &&
                   !(flush_en && (2'(q_in[i].cls) >= flush_lo) &&
                     (2'(q_in[i].cls) <= flush_hi));
            if (keep) begin
                q_out[dst[$clog2(DEPTH)-1:0]] = q_in[i];
                dst = dst + 1'b1;
            end
        end
        cnt_out = dst;
    end
endmodule

// File: rtl/irq_queue_insert.sv
module irq_queue_insert
    import irq_queue_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  irq_entry_t       q_in  [DEPTH],
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             ins_en,
    input  irq_entry_t       entry,
    output irq_entry_t       q_out [DEPTH],
    output logic [CNT_W-1:0] cnt_out,
    output logic             full_drop
);
    logic [CNT_W-1:0] pos;
    logic             dup;
    logic             do_ins;

    always_comb begin
        pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CNT_W'(i) < cnt_in) && (q_in[i].kind < entry.kind))
                pos = pos + 1'b1;
        end
        dup = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CNT_W'(i) == pos) && (CNT_W'(i) < cnt_in) &&
                (q_in[i].kind == entry.kind) && (entry.cls == CLS_EXT))
                dup = 1'b1;
        end
        do_ins    = ins_en && !dup && (cnt_in < CNT_W'(DEPTH));
        full_drop = ins_en && !dup && (cnt_in == CNT_W'(DEPTH));
        cnt_out   = do_ins ? cnt_in + 1'b1 : cnt_in;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == 0) begin : g_first
            assign q_out[g] = (do_ins && pos == '0) ? entry : q_in[g];
        end else begin : g_rest
            assign q_out[g] = (!do_ins || CNT_W'(g) < pos) ? q_in[g] :
                              (CNT_W'(g) == pos)           ? entry   :
                                                             q_in[g-1];
        end
    end
endmodule

// File: rtl/irq_pending_queue.sv
module irq_pending_queue
    import irq_queue_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_en,
    input  logic [3:0]        pil,
    input  logic              enq_valid,
    input  logic [1:0]        enq_cls,
    input  logic [3:0]        enq_level,
    input  logic [2:0]        enq_code,
    input  logic [7:0]        enq_sw_offset,
    input  logic [31:0]       enq_pc,
    input  logic [2:0]        enq_slot,
    input  logic              pop,
    input  logic              flush_en,
    input  logic [1:0]        flush_lo,
    input  logic [1:0]        flush_hi,
    output logic              top_valid,
    output logic [4:0]        top_kind,
    output logic [1:0]        top_cls,
    output logic [7:0]        top_offset,
    output logic [31:0]       top_pc,
    output logic [2:0]        top_slot,
    output logic [CNT_W-1:0]  count,
    output logic              overflow
);
    irq_entry_t       q_r   [DEPTH];
    irq_entry_t       q_fl  [DEPTH];
    irq_entry_t       q_ins [DEPTH];
    logic [CNT_W-1:0] cnt_r, cnt_pop, cnt_fl, cnt_ins;
    logic             ovf_r, full_drop, req_ok;
    irq_entry_t       req_entry, tail;

    irq_req_decode u_dec (
        .enq_valid     (enq_valid),
        .enq_cls       (enq_cls),
        .enq_level     (enq_level),
        .enq_code      (enq_code),
        .enq_sw_offset (enq_sw_offset),
        .enq_pc        (enq_pc),
        .enq_slot      (enq_slot),
        .trap_en       (trap_en),
        .pil           (pil),
        .req_ok        (req_ok),
        .req_entry     (req_entry)
    );

    // tail sits at the top index, so removing it is only a count change
    assign cnt_pop = (pop && cnt_r != '0) ? cnt_r - 1'b1 : cnt_r;

    irq_queue_flush #(.DEPTH(DEPTH)) u_flush (
        .q_in     (q_r),
        .cnt_in   (cnt_pop),
        .flush_en (flush_en),
        .flush_lo (flush_lo),
        .flush_hi (flush_hi),
        .q_out    (q_fl),
        .cnt_out  (cnt_fl)
    );

    irq_queue_insert #(.DEPTH(DEPTH)) u_ins (
        .q_in      (q_fl),
        .cnt_in    (cnt_fl),
        .ins_en    (req_ok),
        .entry     (req_entry),
        .q_out     (q_ins),
        .cnt_out   (cnt_ins),
        .full_drop (full_drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) q_r[i] <= '0;
            cnt_r <= '0;
            ovf_r <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) q_r[i] <= q_ins[i];
            cnt_r <= cnt_ins;
            ovf_r <= ovf_r | full_drop;
        end
    end

    always_comb begin
        tail = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i + 1) == cnt_r) tail = q_r[i];
        end
    end

    assign top_valid  = (cnt_r != '0);
    assign top_kind   = tail.kind;
    assign top_cls    = 2'(tail.cls);
    assign top_offset = tail.offset;
    assign top_pc     = tail.pc;
    assign top_slot   = tail.slot;
    assign count      = cnt_r;
    assign overflow   = ovf_r;
endmodule

// File: rtl/irq_queue_chk.sv
module irq_queue_chk
    import irq_queue_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic             enq_valid,
    input logic [1:0]       enq_cls,
    input logic             trap_en,
    input logic             pop,
    input logic             flush_en,
    input irq_entry_t       q [DEPTH]
);
    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R10
    ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> ($past(cnt) == CNT_W'(DEPTH)));

    // R8
    pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt != '0 && !enq_valid && !flush_en) |=> (cnt == $past(cnt) - 1'b1));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && enq_cls == 2'd0 && !trap_en && !pop && !flush_en) |=> $stable(cnt));

    for (genvar g = 0; g + 1 < DEPTH; g++) begin : g_ord
        // R2
        sorted_order_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt >= CNT_W'(g + 2)) |-> (q[g].kind <= q[g+1].kind));
    end
endmodule

bind irq_pending_queue irq_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt_r),
    .ovf       (ovf_r),
    .enq_valid (enq_valid),
    .enq_cls   (enq_cls),
    .trap_en   (trap_en),
    .pop       (pop),
    .flush_en  (flush_en),
    .q         (q_r)
);

// File: tb/tb_irq_pending_queue.sv
module tb_irq_pending_queue;
    logic        clk = 1'b0;
    logic        rst;
    logic        trap_en;
    logic [3:0]  pil;
    logic        enq_valid;
    logic [1:0]  enq_cls;
    logic [3:0]  enq_level;
    logic [2:0]  enq_code;
    logic [7:0]  enq_sw_offset;
    logic [31:0] enq_pc;
    logic [2:0]  enq_slot;
    logic        pop;
    logic        flush_en;
    logic [1:0]  flush_lo, flush_hi;
    logic        top_valid;
    logic [4:0]  top_kind;
    logic [1:0]  top_cls;
    logic [7:0]  top_offset;
    logic [31:0] top_pc;
    logic [2:0]  top_slot;
    logic [3:0]  count;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    irq_pending_queue dut (
        .clk(clk), .rst(rst), .trap_en(trap_en), .pil(pil),
        .enq_valid(enq_valid), .enq_cls(enq_cls), .enq_level(enq_level),
        .enq_code(enq_code), .enq_sw_offset(enq_sw_offset), .enq_pc(enq_pc),
        .enq_slot(enq_slot), .pop(pop), .flush_en(flush_en),
        .flush_lo(flush_lo), .flush_hi(flush_hi), .top_valid(top_valid),
        .top_kind(top_kind), .top_cls(top_cls), .top_offset(top_offset),
        .top_pc(top_pc), .top_slot(top_slot), .count(count), .overflow(overflow)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        enq_valid = 0;
        pop       = 0;
        flush_en  = 0;
    endtask

    task automatic set_req(input logic [1:0] c, input logic [3:0] lvl,
                           input logic [2:0] code, input logic [7:0] off,
                           input logic [31:0] pc, input logic [2:0] slot);
        enq_valid = 1; enq_cls = c; enq_level = lvl; enq_code = code;
        enq_sw_offset = off; enq_pc = pc; enq_slot = slot;
    endtask

    task automatic enq(input logic [1:0] c, input logic [3:0] lvl,
                       input logic [2:0] code, input logic [7:0] off,
                       input logic [31:0] pc, input logic [2:0] slot);
        set_req(c, lvl, code, off, pc, slot);
        step();
    endtask

    task automatic pop1();
        pop = 1;
        step();
    endtask

    task automatic flush(input logic [1:0] lo, input logic [1:0] hi);
        flush_en = 1; flush_lo = lo; flush_hi = hi;
        step();
    endtask

    task automatic see_top(input string req, input int kind, input int cls,
                           input int off, input int pc, input int slot);
        chk(req, "top_valid", top_valid, 1);
        chk(req, "top_kind", top_kind, kind);
        chk(req, "top_cls", top_cls, cls);
        chk(req, "top_offset", top_offset, off);
        chk(req, "top_pc", top_pc, pc);
        chk(req, "top_slot", top_slot, slot);
    endtask

    task automatic do_reset();
        rst = 1;
        step(); step();
        rst = 0;
    endtask

    task automatic t_reset();
        chk("R1", "count", count, 0);
        chk("R1", "top_valid", top_valid, 0);
        chk("R1", "overflow", overflow, 0);
    endtask

    task automatic t_order();
        trap_en = 1; pil = 0;
        enq(2'd0, 4'd3, 3'd0, 8'h00, 32'h100, 3'd1);
        enq(2'd3, 4'd0, 3'd0, 8'h00, 32'h200, 3'd2);
        enq(2'd2, 4'd0, 3'd2, 8'h00, 32'h300, 3'd3);
        enq(2'd1, 4'd0, 3'd0, 8'h55, 32'h400, 3'd4);
        chk("R2", "count", count, 4);
        see_top("R2 R7 R12 break", 24, 3, 8'hFF, 32'h200, 2);
        pop1();
        see_top("R2 R7 R8 prog", 18, 2, 8'h14, 32'h300, 3);
        pop1();
        see_top("R7 R12 soft", 15, 1, 8'h55, 32'h400, 4);
        pop1();
        see_top("R7 R12 ext", 2, 0, 8'h23, 32'h100, 1);
        pop1();
        chk("R8", "top_valid empty", top_valid, 0);
        pop1();
        chk("R8", "count after pop on empty", count, 0);
    endtask

    task automatic t_mask();
        trap_en = 0; pil = 0;
        enq(2'd0, 4'd15, 3'd0, 8'h00, 32'h10, 3'd0);
        chk("R5", "count trap_en=0 level15", count, 0);
        trap_en = 1; pil = 6;
        enq(2'd0, 4'd6, 3'd0, 8'h00, 32'h11, 3'd0);
        chk("R4", "count level==pil", count, 0);
        enq(2'd0, 4'd7, 3'd0, 8'h00, 32'h12, 3'd0);
        chk("R4", "count level>pil", count, 1);
        see_top("R4 R7", 6, 0, 8'h27, 32'h12, 0);
        pil = 15;
        enq(2'd0, 4'd15, 3'd0, 8'h00, 32'h13, 3'd5);
        chk("R5", "count level15 pil15", count, 2);
        see_top("R5 R7", 14, 0, 8'h2F, 32'h13, 5);
        enq(2'd0, 4'd14, 3'd0, 8'h00, 32'h14, 3'd0);
        chk("R4", "count level14 pil15", count, 2);
        flush(2'd0, 2'd3);
        chk("R9", "count after full-range flush", count, 0);
        pil = 0;
    endtask

    task automatic t_merge();
        enq(2'd0, 4'd7, 3'd0, 8'h00, 32'h10, 3'd1);
        enq(2'd0, 4'd7, 3'd0, 8'h00, 32'h20, 3'd2);
        chk("R6", "count after duplicate", count, 1);
        see_top("R6 keeps first", 6, 0, 8'h27, 32'h10, 1);
        enq(2'd2, 4'd0, 3'd5, 8'h00, 32'h30, 3'd3);
        enq(2'd2, 4'd0, 3'd5, 8'h00, 32'h40, 3'd4);
        chk("R3", "count equal prog kinds", count, 3);
        see_top("R3 older first", 21, 2, 8'h11, 32'h30, 3);
        pop1();
        see_top("R3 newer next", 21, 2, 8'h11, 32'h40, 4);
        pop1();
        see_top("R3 ext below", 6, 0, 8'h27, 32'h10, 1);
        flush(2'd0, 2'd3);
    endtask

    task automatic t_flush();
        enq(2'd0, 4'd2, 3'd0, 8'h00, 32'h1, 3'd0);
        enq(2'd1, 4'd0, 3'd0, 8'h77, 32'h2, 3'd0);
        enq(2'd2, 4'd0, 3'd0, 8'h00, 32'h3, 3'd0);
        enq(2'd2, 4'd0, 3'd5, 8'h00, 32'h4, 3'd0);
        enq(2'd3, 4'd0, 3'd0, 8'h00, 32'h5, 3'd6);
        chk("R9", "count before flush", count, 5);
        flush(2'd1, 2'd2);
        chk("R9", "count after class 1..2 flush", count, 2);
        see_top("R9 break kept", 24, 3, 8'hFF, 32'h5, 6);
        pop1();
        see_top("R9 ext compacted", 1, 0, 8'h22, 32'h1, 0);
        flush(2'd0, 2'd0);
        chk("R9", "count after class 0 flush", count, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++)
            enq(2'd2, 4'd0, 3'(i), 8'h00, 32'(i), 3'd0);
        chk("R10", "count full", count, 8);
        chk("R10", "overflow before", overflow, 0);
        see_top("R10 top full", 23, 2, 8'h0D, 7, 0);
        enq(2'd0, 4'd1, 3'd0, 8'h00, 32'h99, 3'd0);
        chk("R10", "count after drop", count, 8);
        chk("R10", "overflow set", overflow, 1);
        set_req(2'd3, 4'd0, 3'd0, 8'h00, 32'hAB, 3'd7);
        pop = 1;
        step();
        chk("R11", "count pop+enq full", count, 8);
        see_top("R11 new break on top", 24, 3, 8'hFF, 32'hAB, 7);
        step();
        chk("R10", "overflow sticky", overflow, 1);
        flush(2'd0, 2'd3);
        chk("R9", "count flushed", count, 0);
        chk("R10", "overflow survives flush", overflow, 1);
        do_reset();
        chk("R1", "overflow cleared by reset", overflow, 0);
        chk("R1", "count after reset", count, 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; trap_en = 0; pil = 0; enq_valid = 0; enq_cls = 0;
        enq_level = 0; enq_code = 0; enq_sw_offset = 0; enq_pc = 0;
        enq_slot = 0; pop = 0; flush_en = 0; flush_lo = 0; flush_hi = 0;
        #1;
        do_reset();
        t_reset();
        t_order();
        t_mask();
        t_merge();
        t_flush();
        t_full();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule